// File: doc/BRIEF.md
# Logical Device Activation and I/O Range-Check Responder

This block is the per-logical-device control slice of a plug-and-play expansion card. It holds an activation flag, a range-check control byte and a set of 16-bit I/O base address registers. Configuration software reaches these through a byte-wide register write/read port. The block watches I/O reads on the card's bus and decides whether each read lands in one of the programmed I/O windows.

When an address falls inside a window, one of two things happens. If the device is active, the block signals a normal device select so the device function can answer. If the device is inactive but range checking is on, the block drives a fixed test pattern itself, so configuration software can find conflicts before it commits the resources. Only one of these two responses can happen for a read. Range checking cannot be enabled on an active device, and activating the device turns range checking off.

Top module: `ldev_ctrl`

## Requirements
- R1: After `rst`, the activation flag, the range-check byte and every base register are 0, and `io_chk_drive`, `io_dev_sel` and `io_rdata` are 0.
- R2: Configuration address 0x30 holds the activation flag in bit 0 and is read/write. Bits 7:1 always read as 0.
- R3: Configuration address 0x31 holds the range-check enable in bit 1 and the pattern select in bit 0. Bits 7:2 always read as 0.
- R4: A write to 0x31 while the device is active stores the pattern select but leaves the range-check enable at 0.
- R5: A write to 0x30 with bit 0 set clears the range-check enable in the same cycle. The pattern select is kept.
- R6: Base register n (n = 0 to NUM_RANGES-1) takes address bits 15:8 at configuration address 0x60+2n and bits 7:0 at 0x61+2n. Both bytes are read/write.
- R7: An I/O address hits range n when base n is nonzero and base ≤ address < base + RANGE_LEN (default 8). A base of 0 never hits.
- R8: An I/O read that hits while the device is inactive and range check is enabled makes `io_chk_drive`=1 in the next cycle, with `io_rdata` 0x55 when the pattern select is 1 and 0xAA when it is 0.
- R9: An I/O read that hits while the device is active makes `io_dev_sel`=1 and `io_chk_drive`=0 in the next cycle. The two outputs are never 1 together.
- R10: A read that misses, or a cycle without `io_rd_en`, gives `io_chk_drive`=0, `io_dev_sel`=0 and `io_rdata`=0 in the next cycle.
- R11: A one-cycle `cfg_reset` pulse returns the activation flag, the range-check byte and all base registers to 0.
- R12: Configuration addresses other than 0x30, 0x31 and the base bytes read as 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_reset | input | 1 | Configuration-control reset pulse for the logical device |
| cfg_wr_en | input | 1 | Configuration register write strobe |
| cfg_addr | input | 8 | Configuration register address |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data (combinational from `cfg_addr`) |
| io_rd_en | input | 1 | Bus I/O read strobe |
| io_addr | input | 16 | Bus I/O read address |
| io_chk_drive | output | 1 | Block drives the range-check pattern (one cycle after the read) |
| io_rdata | output | 8 | Range-check pattern, 0 otherwise |
| io_dev_sel | output | 1 | Normal decode hit for the active device (one cycle after the read) |

## Verification
The assertions check these invariants on every cycle: the two responses are never given together, a driven byte is always one of the two patterns and is zero otherwise, there is no response without a preceding read, the reserved read bits stay zero, range check is never enabled on an active device, and state is cleared after a configuration reset. Other behaviour needs the bench scenarios: which pattern goes with which select value, the exact window edges, that a zero base is ignored, byte order in the base registers, and that writes to unmapped addresses are dropped.

// File: rtl/ldev_ctrl_pkg.sv
package ldev_ctrl_pkg;

    localparam logic [7:0] CFG_ACTIVATE = 8'h30;
    localparam logic [7:0] CFG_RANGECHK = 8'h31;
    localparam logic [7:0] CFG_BASE0    = 8'h60;

    localparam logic [7:0] PATTERN_SET   = 8'h55;
    localparam logic [7:0] PATTERN_CLEAR = 8'hAA;

    typedef struct packed {
        logic active;
        logic chk_en;
        logic chk_pat;
    } ldev_ctl_t;

    typedef enum logic [1:0] {
        RESP_NONE,
        RESP_CHECK,
        RESP_DEVICE
    } resp_e;

    function automatic logic window_hit(input logic [15:0] base,
                                        input logic [15:0] addr,
                                        input logic [16:0] len);
        logic [16:0] lo;
        logic [16:0] a;
        lo = {1'b0, base};
        a  = {1'b0, addr};
        return (base != 16'h0) && (a >= lo) && (a < lo + len);
    endfunction

endpackage

// File: rtl/ldev_regs.sv
module ldev_regs
    import ldev_ctrl_pkg::*;
#(
    parameter int NUM_RANGES = 8
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           cfg_reset,
    input  logic                           cfg_wr_en,
    input  logic [7:0]                     cfg_addr,
    input  logic [7:0]                     cfg_wdata,
    output logic [7:0]                     cfg_rdata,
    output ldev_ctl_t                      ctl,
    output logic [NUM_RANGES-1:0][15:0]    bases
);
    localparam int BASE_BYTES = 2 * NUM_RANGES;

    logic [7:0] base_off;
    logic       in_base;
    logic       clr;

    assign clr      = rst | cfg_reset;
    assign base_off = cfg_addr - CFG_BASE0;
    assign in_base  = (cfg_addr >= CFG_BASE0) && ({24'h0, base_off} < BASE_BYTES);

    // Control byte: activation refuses / cancels range check.
    always_ff @(posedge clk) begin
        if (clr) begin
            ctl <= '0;
        end else if (cfg_wr_en) begin
            if (cfg_addr == CFG_ACTIVATE) begin
                ctl.active <= cfg_wdata[0];
                if (cfg_wdata[0]) begin
                    ctl.chk_en <= 1'b0;
                end
            end else if (cfg_addr == CFG_RANGECHK) begin
                ctl.chk_pat <= cfg_wdata[0];
                ctl.chk_en  <= cfg_wdata[1] & ~ctl.active;
            end
        end
    end

    for (genvar g = 0; g < NUM_RANGES; g++) begin : g_base
        always_ff @(posedge clk) begin
            if (clr) begin
                bases[g] <= '0;
            end else if (cfg_wr_en && in_base && (base_off[7:1] == 7'(g))) begin
                if (base_off[0]) begin
                    bases[g][7:0] <= cfg_wdata;
                end else begin
                    bases[g][15:8] <= cfg_wdata;
                end
            end
        end
    end

    always_comb begin
        cfg_rdata = 8'h00;
        if (cfg_addr == CFG_ACTIVATE) begin
            cfg_rdata = {7'b0, ctl.active};
        end else if (cfg_addr == CFG_RANGECHK) begin
            cfg_rdata = {6'b0, ctl.chk_en, ctl.chk_pat};
        end else begin
            for (int i = 0; i < NUM_RANGES; i++) begin
                if (in_base && (base_off[7:1] == 7'(i))) begin
                    cfg_rdata = base_off[0] ? bases[i][7:0] : bases[i][15:8];
                end
            end
        end
    end

endmodule

// File: rtl/ldev_decode.sv
module ldev_decode
    import ldev_ctrl_pkg::*;
#(
    parameter int NUM_RANGES = 8,
    parameter int RANGE_LEN  = 8
) (
    input  logic [NUM_RANGES-1:0][15:0] bases,
    input  logic [15:0]                 io_addr,
    output logic                        any_hit
);
    localparam logic [16:0] LEN17 = 17'(RANGE_LEN);

    logic [NUM_RANGES-1:0] hits;

    for (genvar g = 0; g < NUM_RANGES; g++) begin : g_win
        assign hits[g] = window_hit(bases[g], io_addr, LEN17);
    end

    assign any_hit = |hits;

endmodule

// File: rtl/ldev_respond.sv
module ldev_respond
    import ldev_ctrl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       io_rd_en,
    input  logic       hit,
    input  ldev_ctl_t  ctl,
    output logic       io_chk_drive,
    output logic       io_dev_sel,
    output logic [7:0] io_rdata
);
    resp_e kind;

    always_comb begin
        kind = RESP_NONE;
        if (io_rd_en && hit) begin
            if (ctl.active) begin
                kind = RESP_DEVICE;
            end else if (ctl.chk_en) begin
                kind = RESP_CHECK;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            io_chk_drive <= 1'b0;
            io_dev_sel   <= 1'b0;
            io_rdata     <= 8'h00;
        end else begin
            io_chk_drive <= (kind == RESP_CHECK);
            io_dev_sel   <= (kind == RESP_DEVICE);
            io_rdata     <= (kind == RESP_CHECK)
                            ? (ctl.chk_pat ? PATTERN_SET : PATTERN_CLEAR)
                            : 8'h00;
        end
    end

endmodule

// File: rtl/ldev_ctrl.sv
module ldev_ctrl
    import ldev_ctrl_pkg::*;
#(
    parameter int NUM_RANGES = 8,
    parameter int RANGE_LEN  = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_reset,
    input  logic        cfg_wr_en,
    input  logic [7:0]  cfg_addr,
    input  logic [7:0]  cfg_wdata,
    output logic [7:0]  cfg_rdata,
    input  logic        io_rd_en,
    input  logic [15:0] io_addr,
    output logic        io_chk_drive,
    output logic [7:0]  io_rdata,
    output logic        io_dev_sel
);
    ldev_ctl_t                    ctl_q;
    logic [NUM_RANGES-1:0][15:0]  bases_q;
    logic                         hit;

    ldev_regs #(.NUM_RANGES(NUM_RANGES)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_reset (cfg_reset),
        .cfg_wr_en (cfg_wr_en),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .ctl       (ctl_q),
        .bases     (bases_q)
    );

    ldev_decode #(.NUM_RANGES(NUM_RANGES), .RANGE_LEN(RANGE_LEN)) u_decode (
        .bases   (bases_q),
        .io_addr (io_addr),
        .any_hit (hit)
    );

    ldev_respond u_respond (
        .clk          (clk),
        .rst          (rst),
        .io_rd_en     (io_rd_en),
        .hit          (hit),
        .ctl          (ctl_q),
        .io_chk_drive (io_chk_drive),
        .io_dev_sel   (io_dev_sel),
        .io_rdata     (io_rdata)
    );

endmodule

// File: rtl/ldev_ctrl_chk.sv
module ldev_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       cfg_reset,
    input logic [7:0] cfg_addr,
    input logic [7:0] cfg_rdata,
    input logic       io_rd_en,
    input logic       io_chk_drive,
    input logic       io_dev_sel,
    input logic [7:0] io_rdata,
    input logic       active,
    input logic       chk_en
);
    AST_ONE_RESPONDER: assert property (@(posedge clk) disable iff (rst)
        !(io_chk_drive && io_dev_sel)); // R9

    AST_PATTERN_VALUE: assert property (@(posedge clk) disable iff (rst)
        io_chk_drive |-> (io_rdata == 8'h55 || io_rdata == 8'hAA)); // R8

    AST_QUIET_BUS: assert property (@(posedge clk) disable iff (rst)
        !io_chk_drive |-> (io_rdata == 8'h00)); // R10

    AST_NO_UNASKED_RESP: assert property (@(posedge clk) disable iff (rst)
        !$past(io_rd_en) |-> (!io_chk_drive && !io_dev_sel)); // R10

    AST_ACT_RESERVED: assert property (@(posedge clk) disable iff (rst)
        (cfg_addr == 8'h30) |-> (cfg_rdata[7:1] == 7'h0)); // R2

    AST_CHK_RESERVED: assert property (@(posedge clk) disable iff (rst)
        (cfg_addr == 8'h31) |-> (cfg_rdata[7:2] == 6'h0)); // R3

    AST_CHK_NOT_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        active |-> !chk_en); // R4

    AST_CFG_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $past(cfg_reset) |-> (!active && !chk_en)); // R11

endmodule

bind ldev_ctrl ldev_ctrl_chk u_ldev_ctrl_chk (
    .clk          (clk),
    .rst          (rst),
    .cfg_reset    (cfg_reset),
    .cfg_addr     (cfg_addr),
    .cfg_rdata    (cfg_rdata),
    .io_rd_en     (io_rd_en),
    .io_chk_drive (io_chk_drive),
    .io_dev_sel   (io_dev_sel),
    .io_rdata     (io_rdata),
    .active       (ctl_q.active),
    .chk_en       (ctl_q.chk_en)
);

// File: tb/test_ldev_ctrl.sv
`timescale 1ns/1ps
module test_ldev_ctrl;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_reset;
    logic        cfg_wr_en;
    logic [7:0]  cfg_addr;
    logic [7:0]  cfg_wdata;
    logic [7:0]  cfg_rdata;
    logic        io_rd_en;
    logic [15:0] io_addr;
    logic        io_chk_drive;
    logic [7:0]  io_rdata;
    logic        io_dev_sel;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        logic       drive;
        logic       sel;
        logic [7:0] data;
        string      req;
    } exp_t;

    exp_t exp_q[$];

    always #5 clk = ~clk;

    ldev_ctrl i_ldev_ctrl (
        .clk(clk), .rst(rst), .cfg_reset(cfg_reset),
        .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .io_rd_en(io_rd_en), .io_addr(io_addr),
        .io_chk_drive(io_chk_drive), .io_rdata(io_rdata), .io_dev_sel(io_dev_sel)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Monitor: every read accepted at an edge is answered right after it.
    always @(posedge clk) begin
        logic took;
        exp_t e;
        took = io_rd_en && !rst;
        #1;
        if (took) begin
            if (exp_q.size() == 0) begin
                check("scoreboard underflow", 1, 0);
            end else begin
                e = exp_q.pop_front();
                check(e.req, {23'h0, io_chk_drive, io_dev_sel, io_rdata},
                             {23'h0, e.drive, e.sel, e.data});
            end
        end
    end

    task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic cfg_check(input string req, input logic [7:0] a, input logic [7:0] exp);
        @(negedge clk);
        cfg_addr = a;
        #1;
        check(req, {24'h0, cfg_rdata}, {24'h0, exp});
    endtask

    task automatic io_read(input string req, input logic [15:0] a,
                           input logic drv, input logic sel, input logic [7:0] d);
        exp_t e;
        e.drive = drv; e.sel = sel; e.data = d; e.req = req;
        @(negedge clk);
        exp_q.push_back(e);
        io_rd_en = 1'b1; io_addr = a;
        @(negedge clk);
        io_rd_en = 1'b0;
    endtask

    initial begin : watchdog
        #1000000;
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; cfg_reset = 1'b0; cfg_wr_en = 1'b0;
        cfg_addr = 8'h0; cfg_wdata = 8'h0; io_rd_en = 1'b0; io_addr = 16'h0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        cfg_check("R1 activate", 8'h30, 8'h00);
        cfg_check("R1 rangechk", 8'h31, 8'h00);
        cfg_check("R1 base0 hi", 8'h60, 8'h00);
        check("R1 outputs", {29'h0, io_chk_drive, io_dev_sel, |io_rdata}, 32'h0);

        // R2 / R3 reserved bits
        cfg_write(8'h30, 8'hFF);
        cfg_check("R2 activate bit0 only", 8'h30, 8'h01);
        cfg_write(8'h30, 8'h00);
        cfg_check("R2 deactivate", 8'h30, 8'h00);
        cfg_write(8'h31, 8'hFF);
        cfg_check("R3 rangechk bits", 8'h31, 8'h03);

        // R6 base bytes, high first
        cfg_write(8'h60, 8'h03);
        cfg_write(8'h61, 8'h00);
        cfg_write(8'h66, 8'h03);
        cfg_write(8'h67, 8'h10);
        cfg_check("R6 base0 hi", 8'h60, 8'h03);
        cfg_check("R6 base0 lo", 8'h61, 8'h00);
        cfg_check("R6 base3 lo", 8'h67, 8'h10);
        cfg_check("R6 base1 untouched", 8'h62, 8'h00);

        // R7 / R8 / R10 range check with pattern 0x55
        io_read("R8 hit base pattern 55", 16'h0300, 1'b1, 1'b0, 8'h55);
        io_read("R7 last port in window", 16'h0307, 1'b1, 1'b0, 8'h55);
        io_read("R7 one past window", 16'h0308, 1'b0, 1'b0, 8'h00);
        io_read("R7 one below base", 16'h02FF, 1'b0, 1'b0, 8'h00);
        io_read("R7 second range hit", 16'h0312, 1'b1, 1'b0, 8'h55);
        io_read("R7 zero base disabled", 16'h0000, 1'b0, 1'b0, 8'h00);
        @(negedge clk); #2;
        check("R10 idle cycle", {29'h0, io_chk_drive, io_dev_sel, |io_rdata}, 32'h0);

        // R8 pattern 0xAA
        cfg_write(8'h31, 8'h02);
        io_read("R8 pattern AA", 16'h0304, 1'b1, 1'b0, 8'hAA);

        // R5 activation cancels range check, keeps pattern select
        cfg_write(8'h31, 8'h03);
        cfg_write(8'h30, 8'h01);
        cfg_check("R5 range check cleared", 8'h31, 8'h01);
        io_read("R9 active device select", 16'h0300, 1'b0, 1'b1, 8'h00);
        io_read("R9 active miss", 16'h0400, 1'b0, 1'b0, 8'h00);

        // R4 range check refused while active
        cfg_write(8'h31, 8'h02);
        cfg_check("R4 enable refused", 8'h31, 8'h00);
        io_read("R4 no pattern while active", 16'h0313, 1'b0, 1'b1, 8'h00);

        // R12 unmapped addresses
        cfg_write(8'h40, 8'h5A);
        cfg_check("R12 unmapped reads zero", 8'h40, 8'h00);
        cfg_write(8'h70, 8'hC3);
        cfg_check("R12 past last base", 8'h70, 8'h00);
        cfg_check("R12 state kept", 8'h60, 8'h03);

        // R11 configuration reset
        cfg_write(8'h30, 8'h00);
        cfg_write(8'h31, 8'h03);
        @(negedge clk); cfg_reset = 1'b1;
        @(negedge clk); cfg_reset = 1'b0;
        cfg_check("R11 activate cleared", 8'h30, 8'h00);
        cfg_check("R11 rangechk cleared", 8'h31, 8'h00);
        cfg_check("R11 base cleared", 8'h67, 8'h00);
        io_read("R11 no decode after reset", 16'h0300, 1'b0, 1'b0, 8'h00);

        repeat (3) @(negedge clk);
        check("scoreboard drained", exp_q.size(), 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule